// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes from a small holding FIFO into asynchronous serial frames on a single output line. Each frame begins with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and the frame ends with one or two high stop bits. A static mode word selects the character length, the parity kind and the number of stop bits. The block samples the mode word each time it launches a frame, so the format never changes partway through a character.

A baud-rate generator outside the block supplies a one-cycle enable tick, and every serial bit lasts a fixed number of these ticks (sixteen by default). A command strobe carries one-hot command bits:

- enable the transmitter
- disable the transmitter
- begin a break
- end a break
- flush the transmit path

The write side is a valid/ready stream. The FIFO state is visible as plain empty and full flags.

Write-port rules: a byte is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the FIFO is full. A writer may hold `wr_valid` and `wr_data` until `wr_ready` returns. A byte offered while `wr_ready` is low is not stored.

Top module: `serial_frame_tx`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits. Each bit after the start bit lasts exactly 16 baud ticks. The start bit ends on the 16th tick after the line falls.
- R2: Mode bits [2:1] set the character length: 00 gives 8 bits, 10 gives 7 bits, 11 gives 6 bits, and 01 is treated as 8 bits. Only the low bits of the stored byte are sent.
- R3: Mode bits [5:3] set the parity: 000 is even, 001 is odd, 010 is space (always 0), 011 is mark (always 1), and 1xx sends no parity bit. Even and odd parity are taken over the sent data bits only.
- R4: Mode bit 7 set gives two stop bits; clear gives one.
- R5: A `ctrl_wr` strobe with `ctrl_cmd` bit 4 enables the transmitter, and bit 5 disables it; bit 5 wins when both are set. While disabled, no frame starts, the line stays high and the FIFO contents are kept. A frame already in progress completes.
- R6: When another byte is waiting and the transmitter is enabled, the next start bit begins in the same cycle the last stop bit ends. There is no idle gap between frames.
- R7: `ctrl_cmd` bit 7 starts a break and bit 8 ends it; bit 8 wins when both are set. From idle, the line goes low two clock edges after the strobe. During a frame, the line goes low only once that frame's last stop bit ends. Ending the break returns the line high two edges after the strobe.
- R8: `ctrl_cmd` bit 1 empties the FIFO, drops any write offered in the same cycle, aborts any frame, drives the line high and clears the break. The enable state is unchanged.
- R9: The FIFO holds 16 bytes. `fifo_full` and `fifo_empty` report its fill level one edge after a write or read. Writes offered while full are not accepted and are never sent.
- R10: After reset the line is high, `fifo_empty` is 1, `fifo_full` is 0, the transmitter is disabled and no break is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write stream: byte offered |
| wr_ready | output | 1 | Write stream: FIFO can take a byte |
| wr_data | input | 8 | Write stream: byte to send |
| ctrl_wr | input | 1 | Command strobe, one cycle |
| ctrl_cmd | input | 9 | Command bits: 1 flush, 4 enable, 5 disable, 7 break on, 8 break off |
| mode | input | 8 | Frame format: [2:1] length, [5:3] parity, [7] stop count |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| txd | output | 1 | Serial output line, idle high |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_full | output | 1 | FIFO holds 16 bytes |

## Verification
A command strobe updates the command registers at the first edge. The line reacts at the second edge, so break, break-release and flush effects are sampled on the third falling clock edge after the strobe. The FIFO flags settle one edge after the write that changes them and are read on the following falling edge. The line decoder starts timing at the falling edge of the start bit. It samples 8 tick periods later and then every 16 tick periods, so each bit is read near its centre whatever the start bit's phase against the tick. The decoder also checks spacing in back-to-back bursts: the interval between two start edges must fall within one tick period of the previous frame's bit count times 16 tick periods.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int CMD_W       = 9;
  localparam int CMD_FLUSH   = 1;
  localparam int CMD_EN      = 4;
  localparam int CMD_DIS     = 5;
  localparam int CMD_BRK_ON  = 7;
  localparam int CMD_BRK_OFF = 8;
  localparam int MODE_W      = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } stx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic [1:0] par_kind;
    logic       two_stop;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m);
    frame_cfg_t c;
    case (m[2:1])
      2'b10:   c.nbits = 4'd7;
      2'b11:   c.nbits = 4'd6;
      default: c.nbits = 4'd8;
    endcase
    c.par_en   = ~m[5];
    c.par_kind = m[4:3];
    c.two_stop = m[7];
    return c;
  endfunction
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign pop_data = mem[rp];
  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));

  // R9
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R9
  fifo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> !empty);
endmodule

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import stx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd,
  output logic             tx_en,
  output logic             brk_req,
  output logic             flush
);
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd[0], cmd[3:2], cmd[6]};

  assign flush = cmd_wr & cmd[CMD_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      brk_req <= 1'b0;
    end else if (cmd_wr) begin
      if (cmd[CMD_DIS])     tx_en <= 1'b0;
      else if (cmd[CMD_EN]) tx_en <= 1'b1;
      if (cmd[CMD_FLUSH] || cmd[CMD_BRK_OFF]) brk_req <= 1'b0;
      else if (cmd[CMD_BRK_ON])               brk_req <= 1'b1;
    end
  end

  // R5
  dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd[CMD_DIS]) |=> !tx_en);
  // R7
  brk_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd[CMD_BRK_OFF]) |=> !brk_req);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              flush,
  input  logic [MODE_W-1:0] mode,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              pop,
  output logic              txd
);
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;

  stx_state_e        state;
  logic [TW-1:0]     tick_cnt;
  logic [DATA_W-1:0] sh;
  logic [3:0]        left;
  logic              par_bit;
  logic              stop_more;
  logic              txd_q;
  frame_cfg_t        cfg_q, cfg_new;
  logic [DATA_W-1:0] data_m;
  logic              par_new;
  logic              bit_end, in_frame, can_launch, frame_done;

  logic unused_mode_bits;
  assign unused_mode_bits = ^{mode[0], mode[6]};

  assign cfg_new    = decode_mode(mode);
  assign bit_end    = baud_tick && (tick_cnt == TW'(OVS - 1));
  assign in_frame   = state inside {ST_START, ST_DATA, ST_PAR, ST_STOP};
  assign can_launch = tx_en && !fifo_empty && !brk_req;
  assign frame_done = (state == ST_STOP) && bit_end && !stop_more;
  assign pop        = !flush && can_launch && ((state == ST_IDLE) || frame_done);

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      data_m[i] = fifo_data[i] & (4'(i) < cfg_new.nbits);
    case (cfg_new.par_kind)
      2'd0:    par_new = ^data_m;
      2'd1:    par_new = ~^data_m;
      2'd2:    par_new = 1'b0;
      default: par_new = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tick_cnt  <= '0;
      sh        <= '0;
      left      <= '0;
      par_bit   <= 1'b0;
      stop_more <= 1'b0;
      cfg_q     <= '0;
      txd_q     <= 1'b1;
    end else if (flush) begin
      state     <= ST_IDLE;
      tick_cnt  <= '0;
      stop_more <= 1'b0;
      txd_q     <= 1'b1;
    end else if (pop) begin
      state    <= ST_START;
      tick_cnt <= '0;
      sh       <= data_m;
      left     <= cfg_new.nbits;
      par_bit  <= par_new;
      cfg_q    <= cfg_new;
      txd_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (brk_req) begin
          state <= ST_BRK;
          txd_q <= 1'b0;
        end
        ST_BRK: if (!brk_req) begin
          state <= ST_IDLE;
          txd_q <= 1'b1;
        end
        default: if (baud_tick) begin
          tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
          if (bit_end) begin
            case (state)
              ST_START: begin
                state <= ST_DATA;
                txd_q <= sh[0];
                sh    <= sh >> 1;
                left  <= left - 1'b1;
              end
              ST_DATA: begin
                if (left != 4'd0) begin
                  txd_q <= sh[0];
                  sh    <= sh >> 1;
                  left  <= left - 1'b1;
                end else if (cfg_q.par_en) begin
                  state <= ST_PAR;
                  txd_q <= par_bit;
                end else begin
                  state     <= ST_STOP;
                  txd_q     <= 1'b1;
                  stop_more <= cfg_q.two_stop;
                end
              end
              ST_PAR: begin
                state     <= ST_STOP;
                txd_q     <= 1'b1;
                stop_more <= cfg_q.two_stop;
              end
              default: begin
                if (stop_more) begin
                  stop_more <= 1'b0;
                end else if (brk_req) begin
                  state <= ST_BRK;
                  txd_q <= 1'b0;
                end else begin
                  state <= ST_IDLE;
                  txd_q <= 1'b1;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assign txd = txd_q;

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (!txd && state == ST_START));
  // R1
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !baud_tick && !flush && !pop) |=> $stable(tick_cnt));
  // R7
  brk_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRK) |-> !txd);
  // R5
  idle_disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !tx_en && !brk_req) |=> txd);
  // R8
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (txd && state == ST_IDLE));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import stx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctrl_wr,
  input  logic [CMD_W-1:0]  ctrl_cmd,
  input  logic [MODE_W-1:0] mode,
  input  logic              baud_tick,
  output logic              txd,
  output logic              fifo_empty,
  output logic              fifo_full
);
  logic              tx_en, brk_req, flush, push, pop;
  logic [DATA_W-1:0] head;

  assign wr_ready = !fifo_full;
  assign push     = wr_valid && wr_ready && !flush;

  stx_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (ctrl_wr),
    .cmd     (ctrl_cmd),
    .tx_en   (tx_en),
    .brk_req (brk_req),
    .flush   (flush)
  );

  stx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (wr_data),
    .pop       (pop),
    .pop_data  (head),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  stx_shifter #(.OVS(OVS), .DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_en      (tx_en),
    .brk_req    (brk_req),
    .flush      (flush),
    .mode       (mode),
    .fifo_empty (fifo_empty),
    .fifo_data  (head),
    .pop        (pop),
    .txd        (txd)
  );
endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BITC       = 16 * TICK_DIV;
  localparam logic [8:0] C_RST = 9'h002, C_EN = 9'h010, C_DIS = 9'h020,
                         C_BON = 9'h080, C_BOFF = 9'h100;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, ctrl_wr = 0, baud_tick = 0;
  logic [7:0] wr_data = 0, mode = 0;
  logic [8:0] ctrl_cmd = 0;
  logic wr_ready, txd, fifo_empty, fifo_full;

  int checks = 0, fails = 0, frames_done = 0, cyc = 0;
  int cur_len = 8, cur_par = 4, cur_two = 0;
  bit brk_on = 0, b2b_on = 0, last_valid = 0, done = 0;
  int last_ts = 0, last_bits = 0;
  logic mon_prev = 1;
  logic [7:0] exp_q[$];

  serial_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ctrl_wr(ctrl_wr), .ctrl_cmd(ctrl_cmd), .mode(mode),
    .baud_tick(baud_tick), .txd(txd), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % TICK_DIV;
      baud_tick = (ph == 0);
    end
  end

  function automatic logic [7:0] mode_of(int len, int par, int two);
    logic [1:0] l = (len == 7) ? 2'b10 : (len == 6) ? 2'b11 : 2'b00;
    return {two[0], 1'b0, par[2:0], l, 1'b0};
  endfunction

  function automatic logic exp_par(logic [7:0] d, int par);
    case (par)
      0: return ^d;
      1: return ~^d;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic decode_frame();
    int ts = cyc;
    int nb = 1 + cur_len + ((cur_par != 4) ? 1 : 0) + (cur_two ? 2 : 1);
    logic [7:0] got = 0, msk = 8'((1 << cur_len) - 1), e;
    logic pb = 0;
    repeat (BITC/2) @(negedge clk);
    chk(txd == 0, "R1 start bit low", txd, 0);
    for (int i = 0; i < cur_len; i++) begin
      repeat (BITC) @(negedge clk);
      got[i] = txd;
    end
    if (cur_par != 4) begin
      repeat (BITC) @(negedge clk);
      pb = txd;
    end
    for (int s = 0; s < (cur_two ? 2 : 1); s++) begin
      repeat (BITC) @(negedge clk);
      chk(txd == 1, "R4 stop bit high", txd, 1);
    end
    if (exp_q.size() == 0) chk(0, "R9 unexpected frame", got, -1);
    else begin
      e = exp_q.pop_front() & msk;
      chk(got == e, "R2 data bits", got, e);
      if (cur_par != 4) chk(pb == exp_par(e, cur_par), "R3 parity bit", pb, exp_par(e, cur_par));
    end
    if (b2b_on && last_valid)
      chk((ts - last_ts) <= last_bits*BITC && (ts - last_ts) > last_bits*BITC - TICK_DIV,
          "R6 frame spacing", ts - last_ts, last_bits*BITC);
    last_ts = ts; last_bits = nb; last_valid = 1;
    frames_done++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mon_prev === 1'b1 && txd === 1'b0 && !brk_on) decode_frame();
      mon_prev = txd;
    end
  end

  task automatic do_cmd(input logic [8:0] c);
    @(negedge clk); ctrl_cmd = c; ctrl_wr = 1;
    @(negedge clk); ctrl_wr = 0; ctrl_cmd = 0;
  endtask

  task automatic write_byte(input logic [7:0] d, output bit acc);
    @(negedge clk); wr_valid = 1; wr_data = d; acc = wr_ready;
    if (acc) exp_q.push_back(d);
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic wait_frames(input int target, input string req);
    int t = 0;
    while (frames_done < target && t < 30000) begin @(negedge clk); t++; end
    chk(frames_done >= target, req, frames_done, target);
  endtask

  task automatic set_fmt(int len, int par, int two);
    cur_len = len; cur_par = par; cur_two = two;
    mode = mode_of(len, par, two);
  endtask

  task automatic run_burst(int n, int len, int par, int two, string req);
    bit acc;
    int base = frames_done;
    do_cmd(C_DIS);
    set_fmt(len, par, two);
    last_valid = 0; b2b_on = 1;
    for (int i = 0; i < n; i++) write_byte(8'($urandom), acc);
    do_cmd(C_EN);
    wait_frames(base + n, req);
    do_cmd(C_DIS);
    b2b_on = 0;
    repeat (2) @(negedge clk);
    chk(fifo_empty == 1, "R9 empty after burst", fifo_empty, 1);
  endtask

  initial begin
    repeat (int'(CLK_PERIOD*50)) @(posedge clk);
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    int base, nacc;
    void'($urandom(32'h5EED_1234));
    set_fmt(8, 4, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R10 line high", txd, 1);
    chk(fifo_empty == 1, "R10 empty", fifo_empty, 1);
    chk(fifo_full == 0, "R10 not full", fifo_full, 0);
    chk(wr_ready == 1, "R10 ready", wr_ready, 1);

    // R10 / R5: disabled after reset, byte is kept
    write_byte(8'hA5, acc);
    repeat (3*BITC) @(negedge clk);
    chk(frames_done == 0 && txd == 1, "R10 disabled after reset", frames_done, 0);
    chk(fifo_empty == 0, "R5 fifo kept while disabled", fifo_empty, 0);

    // R8: flush empties the FIFO
    do_cmd(C_RST); exp_q.delete();
    repeat (2) @(negedge clk);
    chk(fifo_empty == 1, "R8 flush empties", fifo_empty, 1);

    // R5: enable and disable together -> stays disabled
    write_byte(8'h3C, acc); write_byte(8'hC3, acc);
    do_cmd(C_EN | C_DIS);
    repeat (3*BITC) @(negedge clk);
    chk(frames_done == 0 && txd == 1, "R5 disable wins", frames_done, 0);
    chk(fifo_empty == 0, "R5 fifo kept", fifo_empty, 0);
    do_cmd(C_EN);
    wait_frames(2, "R5 enable sends kept bytes");
    do_cmd(C_DIS);

    // directed formats: mark, space, odd, even, two stop, lengths
    run_burst(3, 7, 3, 0, "R3 mark parity");
    run_burst(3, 6, 2, 1, "R3 space parity");
    run_burst(4, 8, 1, 0, "R3 odd parity");
    run_burst(4, 8, 0, 1, "R4 two stop even");
    run_burst(5, 6, 4, 0, "R2 six bits no parity");

    // R9: fill to 16, extra writes refused
    do_cmd(C_DIS); set_fmt(8, 4, 0);
    nacc = 0;
    for (int i = 0; i < 18; i++) begin
      write_byte(8'(i * 17 + 3), acc);
      if (acc) nacc++;
    end
    chk(nacc == 16, "R9 sixteen accepted", nacc, 16);
    chk(fifo_full == 1 && wr_ready == 0, "R9 full flag", fifo_full, 1);
    base = frames_done; last_valid = 0; b2b_on = 1;
    do_cmd(C_EN);
    wait_frames(base + 16, "R9 drain sixteen");
    b2b_on = 0;
    repeat (3*BITC) @(negedge clk);
    chk(frames_done == base + 16, "R9 refused byte not sent", frames_done, base + 16);
    chk(fifo_empty == 1, "R9 empty after drain", fifo_empty, 1);

    // R7: break from idle (enabled, FIFO empty)
    brk_on = 1;
    do_cmd(C_BON);
    repeat (3) @(negedge clk);
    chk(txd == 0, "R7 break low from idle", txd, 0);
    do_cmd(C_BOFF);
    repeat (3) @(negedge clk);
    chk(txd == 1, "R7 break release high", txd, 1);
    brk_on = 0;
    do_cmd(C_BON | C_BOFF);
    repeat (3) @(negedge clk);
    chk(txd == 1, "R7 stop wins over start", txd, 1);

    // R7: break during a frame waits for the frame to finish
    do_cmd(C_DIS);
    base = frames_done;
    write_byte(8'h96, acc);
    do_cmd(C_EN);
    repeat (3*BITC) @(negedge clk);
    brk_on = 1;
    do_cmd(C_BON);
    wait_frames(base + 1, "R7 frame completes under break");
    repeat (12*TICK_DIV) @(negedge clk);
    chk(txd == 0, "R7 low after frame", txd, 0);
    do_cmd(C_BOFF);
    repeat (3) @(negedge clk);
    chk(txd == 1, "R7 high after stop break", txd, 1);
    brk_on = 0;

    // R8: flush clears an active break, enable unchanged
    brk_on = 1;
    do_cmd(C_BON);
    repeat (3) @(negedge clk);
    chk(txd == 0, "R7 break on again", txd, 0);
    do_cmd(C_RST);
    repeat (3) @(negedge clk);
    chk(txd == 1, "R8 flush clears break", txd, 1);
    repeat (BITC) @(negedge clk);
    brk_on = 0;
    base = frames_done;
    write_byte(8'h5A, acc);
    wait_frames(base + 1, "R8 enable kept after flush");
    do_cmd(C_DIS);

    // random formats
    for (int it = 0; it < 12; it++) begin
      int len = 6 + ($urandom % 3);
      run_burst(1 + ($urandom % 6), len, $urandom % 5, $urandom % 2, "R1 random frames");
    end

    repeat (BITC) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule